// File: doc/BRIEF.md
# Flyby DMA Channel Controller

This block is one DMA channel that moves items between an I/O device and memory without holding the data itself. When the device raises its request and the channel is enabled, the controller asks the CPU for the system bus. Once the CPU grants it, the controller spends exactly one bus cycle per item. In that cycle it drives the memory address and a read or write strobe, and it acknowledges the device. The device then drives the data bus or latches from it. The controller never holds the data in a register of its own.

Software loads an enable bit, a direction bit, a transfer mode, a start address and an item count through a four-slot write port. Three modes are available:

- **Single:** one item per request assertion. The bus is handed back after every item.
- **Block:** one request runs the whole programmed count back to back.
- **Demand:** items run only while the device keeps its request high.

When the count reaches zero the controller releases the bus and raises an interrupt. The interrupt stays high until software clears it.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: While the enable bit (control slot 0, bit 0) is 0, a device request never causes a bus request or a transfer.
- R2: Before any transfer `bus_req` is raised, and `dev_ack`, `mem_rd`, `mem_wr` and `mem_addr` stay at 0 until `bus_gnt` has been seen high.
- R3: Each item takes exactly one cycle. In that cycle `dev_ack` is 1, `mem_addr` is the current address, and exactly one strobe is high: `mem_wr` when the direction bit (slot 0, bit 1) is 1 (device to memory), `mem_rd` when it is 0. Outside these cycles all four outputs are 0.
- R4: After each item the address grows by `ADDR_STEP` (1 by default) and the count drops by one. The address is kept across transfers unless it is rewritten.
- R5: After the item that brings the count to zero, `bus_req` is 0 on the next cycle and `irq` is 1. With a count of zero no transfer starts.
- R6: `irq` holds at 1 until a write to slot 3 with bit 0 set. A write to slot 3 with bit 0 clear leaves it at 1.
- R7: In single mode (slot 0 bits 3:2 = 00), one assertion of the request moves one item, however long it is held. `bus_req` is 0 for at least the cycle after every item.
- R8: In block mode (bits 3:2 = 01), one request, even if dropped right away, moves the whole count on consecutive cycles while the bus is held.
- R9: In demand mode (bits 3:2 = 10), an item whose cycle sees the request low is the last one before the bus is released. Transfers resume from the next address when the request returns.
- R10: Writes to the address slot (1) or the count slot (2) are ignored while a transfer is under way (bus requested or held).
- R11: After reset `bus_req`, `dev_ack`, `mem_rd`, `mem_wr` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Slot: 0 control, 1 address, 2 count, 3 status clear |
| reg_wdata | input | DW | Write data |
| dev_req | input | 1 | Device service request |
| dev_ack | output | 1 | Device acknowledge, one pulse per item |
| bus_req | output | 1 | Bus request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| mem_addr | output | AW | Memory address during an item cycle |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| irq | output | 1 | Completion interrupt |

## Verification
The bench drives each mode with a distinct request pattern:

- **Single mode:** a request held far past its acknowledge. This separates edge-like, once-per-assertion service from level service, which would move extra items.
- **Block mode:** a request pulse that drops as soon as the bus is requested. This shows whether the whole count runs without the request and without gaps.
- **Demand mode:** a request that drops after two items and later returns. This separates a true pause-and-resume from either stopping for good or ignoring the drop.

A withheld grant, a disabled channel, an exhausted count and an address write during a block run show that nothing moves early and that the address state is protected.

// File: rtl/dma_fly_pkg.sv
package dma_fly_pkg;

   typedef enum logic [1:0] {
      XM_SINGLE = 2'b00,
      XM_BLOCK  = 2'b01,
      XM_DEMAND = 2'b10,
      XM_RSVD   = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'b00,
      SQ_ARB  = 2'b01,
      SQ_MOVE = 2'b10
   } seq_state_e;

   localparam logic [1:0] SLOT_CTRL = 2'd0;
   localparam logic [1:0] SLOT_ADDR = 2'd1;
   localparam logic [1:0] SLOT_CNT  = 2'd2;
   localparam logic [1:0] SLOT_STAT = 2'd3;

endpackage

// File: rtl/dma_fly_regs.sv
module dma_fly_regs
   import dma_fly_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned CW        = 12,
   parameter int unsigned DW        = 16,
   parameter int unsigned ADDR_STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          busy,
   input  logic          step,
   output logic          enable,
   output logic          dir_to_mem,
   output xfer_mode_e    mode,
   output logic [AW-1:0] cur_addr,
   output logic          cnt_nz,
   output logic          cnt_last,
   output logic          irq
);

   logic [CW-1:0] cnt_q;
   logic [AW-1:0] addr_nxt;
   logic          clr_hit;

   if (AW > DW) begin : g_chk_aw
      $error("dma_fly_regs: AW must not exceed DW");
   end
   if (CW > DW) begin : g_chk_cw
      $error("dma_fly_regs: CW must not exceed DW");
   end
   if (ADDR_STEP < 1) begin : g_chk_step
      $error("dma_fly_regs: ADDR_STEP must be at least 1");
   end

   if (ADDR_STEP == 1) begin : g_inc_one
      assign addr_nxt = cur_addr + 1'b1;
   end else begin : g_inc_n
      assign addr_nxt = cur_addr + AW'(ADDR_STEP);
   end

   assign cnt_nz   = (cnt_q != '0);
   assign cnt_last = (cnt_q == CW'(1));
   assign clr_hit  = wr_en && (wr_sel == SLOT_STAT) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable     <= 1'b0;
         dir_to_mem <= 1'b0;
         mode       <= XM_SINGLE;
      end else if (wr_en && wr_sel == SLOT_CTRL) begin
         enable     <= wr_data[0];
         dir_to_mem <= wr_data[1];
         mode       <= xfer_mode_e'(wr_data[3:2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
      end else if (step) begin
         cur_addr <= addr_nxt;
      end else if (wr_en && wr_sel == SLOT_ADDR && !busy) begin
         cur_addr <= wr_data[AW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (wr_en && wr_sel == SLOT_CNT && !busy) begin
         cnt_q <= wr_data[CW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (step && cnt_last) begin
         irq <= 1'b1;
      end else if (clr_hit) begin
         irq <= 1'b0;
      end
   end

   // R4: an item is never moved with an empty count
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> cnt_nz);
   // R5: the final item raises the interrupt
   p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_last) |=> irq);
   // R6: the interrupt only falls on a status-clear write
   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_hit) |=> irq);

endmodule

// File: rtl/dma_fly_seq.sv
module dma_fly_seq
   import dma_fly_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  xfer_mode_e mode,
   input  logic       cnt_nz,
   input  logic       cnt_last,
   input  logic       dev_req,
   input  logic       bus_gnt,
   output logic       bus_req,
   output logic       move,
   output logic       busy
);

   seq_state_e state_q, state_d;
   logic       req_used_q;
   logic       start_ok;
   logic       carry_on;
   logic       is_single;

   assign is_single = (mode != XM_BLOCK) && (mode != XM_DEMAND);
   assign start_ok  = enable && cnt_nz && dev_req && !(is_single && req_used_q);

   always_comb begin
      unique case (mode)
         XM_BLOCK:  carry_on = 1'b1;
         XM_DEMAND: carry_on = dev_req;
         default:   carry_on = 1'b0;
      endcase
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: if (start_ok) state_d = SQ_ARB;
         SQ_ARB:  if (bus_gnt) state_d = SQ_MOVE;
         SQ_MOVE: begin
            if (cnt_last || !carry_on) state_d = SQ_IDLE;
            else if (!bus_gnt)         state_d = SQ_ARB;
            else                       state_d = SQ_MOVE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

   // remembers that the present request assertion was already served
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           req_used_q <= 1'b0;
      else if (state_q == SQ_MOVE && is_single) req_used_q <= 1'b1;
      else if (!dev_req)                    req_used_q <= 1'b0;
   end

   assign bus_req = (state_q == SQ_ARB) || (state_q == SQ_MOVE);
   assign move    = (state_q == SQ_MOVE);
   assign busy    = bus_req;

   // R1: a disabled idle channel stays idle
   p_idle_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_IDLE && !enable) |=> !bus_req);
   // R2: no item without a grant
   p_wait_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_ARB && !bus_gnt) |=> !move);
   // R5: bus released after the last item
   p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (move && cnt_last) |=> !bus_req);
   // R7: single mode hands the bus back after each item
   p_single_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (move && is_single) |=> !bus_req);
   // R8: block mode keeps moving while granted
   p_block_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (move && mode == XM_BLOCK && !cnt_last && bus_gnt) |=> move);
   // R9: demand mode stops when the request is gone
   p_demand_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (move && mode == XM_DEMAND && !dev_req) |=> !move);

endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl
   import dma_fly_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned CW        = 12,
   parameter int unsigned DW        = 16,
   parameter int unsigned ADDR_STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_sel,
   input  logic [DW-1:0] reg_wdata,
   input  logic          dev_req,
   output logic          dev_ack,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          irq
);

   logic          enable;
   logic          dir_to_mem;
   xfer_mode_e    mode;
   logic [AW-1:0] cur_addr;
   logic          cnt_nz;
   logic          cnt_last;
   logic          move;
   logic          busy;

   dma_fly_regs #(
      .AW(AW), .CW(CW), .DW(DW), .ADDR_STEP(ADDR_STEP)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .wr_sel     (reg_sel),
      .wr_data    (reg_wdata),
      .busy       (busy),
      .step       (move),
      .enable     (enable),
      .dir_to_mem (dir_to_mem),
      .mode       (mode),
      .cur_addr   (cur_addr),
      .cnt_nz     (cnt_nz),
      .cnt_last   (cnt_last),
      .irq        (irq)
   );

   dma_fly_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .mode     (mode),
      .cnt_nz   (cnt_nz),
      .cnt_last (cnt_last),
      .dev_req  (dev_req),
      .bus_gnt  (bus_gnt),
      .bus_req  (bus_req),
      .move     (move),
      .busy     (busy)
   );

   assign dev_ack  = move;
   assign mem_addr = move ? cur_addr : '0;
   assign mem_wr   = move && dir_to_mem;
   assign mem_rd   = move && !dir_to_mem;

   // R3: exactly one strobe per item cycle
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> ($countones({mem_rd, mem_wr}) == 1));
   // R3: the bus lines are quiet between items
   p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_ack |-> (!mem_rd && !mem_wr && mem_addr == '0));
   // R2: an item cycle always sits inside a bus request
   p_ack_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> bus_req);

endmodule

// File: tb/dma_flyby_ctrl_tb.sv
module dma_flyby_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic        dev_req = 1'b0;
   logic        dev_ack;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic        irq;

   typedef struct packed {
      logic [15:0] a;
      logic        w;
   } item_t;

   item_t exp_q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   int    first_ack = -1;
   int    last_ack = -1;
   logic  gnt_allow = 1'b1;
   logic  gap_chk = 1'b0;
   logic  prev_ack = 1'b0;
   logic  done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   dma_flyby_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq)
   );

   task automatic chk(input logic ok, input string req,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic push_items(input logic [15:0] a0, input int n, input logic w);
      for (int i = 0; i < n; i++) exp_q.push_back('{a: a0 + 16'(i), w: w});
   endtask

   // CPU model: grant follows request by half a cycle
   always @(negedge clk) bus_gnt <= bus_req && gnt_allow;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected items as item cycles appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (gap_chk && prev_ack)
            chk(bus_req == 1'b0, "R7 bus released after item", 32'(bus_req), 0);
         if (dev_ack) begin
            if (first_ack < 0) first_ack = cyc;
            last_ack = cyc;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7/R8/R9 unexpected item", 32'(mem_addr), 0);
            end else begin
               item_t e;
               e = exp_q.pop_front();
               chk(mem_addr == e.a, "R3/R4 item address", 32'(mem_addr), 32'(e.a));
               chk(mem_wr == e.w && mem_rd == !e.w, "R3 strobe direction",
                   {30'd0, mem_wr, mem_rd}, {30'd0, e.w, !e.w});
            end
         end
         prev_ack = dev_ack;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk({bus_req, dev_ack, mem_rd, mem_wr, irq} == 5'b0, "R11 reset outputs",
          32'({bus_req, dev_ack, mem_rd, mem_wr, irq}), 0);

      // R1 disabled channel ignores requests
      wr_reg(2'd1, 16'h0010);
      wr_reg(2'd2, 16'd2);
      wr_reg(2'd0, 16'h0002);
      dev_req = 1'b1;
      repeat (8) begin
         @(negedge clk);
         chk(!bus_req && !dev_ack, "R1 no activity while disabled",
             32'({bus_req, dev_ack}), 0);
      end
      dev_req = 1'b0;

      // single mode, device to memory, three items
      wr_reg(2'd1, 16'h0100);
      wr_reg(2'd2, 16'd3);
      wr_reg(2'd0, 16'h0003);
      push_items(16'h0100, 3, 1'b1);
      gap_chk = 1'b1;
      for (int i = 0; i < 3; i++) begin
         if (i == 0) gnt_allow = 1'b0;
         dev_req = 1'b1;
         if (i == 0) begin
            repeat (4) @(negedge clk);
            chk(bus_req && !dev_ack && !mem_wr && mem_addr == 16'h0,
                "R2 wait for grant", 32'({bus_req, dev_ack, mem_wr}), 32'h4);
            gnt_allow = 1'b1;
         end
         do @(negedge clk); while (!dev_ack);
         repeat (5) @(negedge clk);   // held request must not move more
         dev_req = 1'b0;
         repeat (2) @(negedge clk);
      end
      gap_chk = 1'b0;
      chk(exp_q.size() == 0, "R7 one item per assertion", exp_q.size(), 0);
      chk(irq == 1'b1 && bus_req == 1'b0, "R5 completion irq and release",
          32'({irq, bus_req}), 32'h2);

      // R6 irq holding and clearing
      repeat (5) @(negedge clk);
      chk(irq == 1'b1, "R6 irq held", 32'(irq), 1);
      wr_reg(2'd3, 16'h0000);
      chk(irq == 1'b1, "R6 clear with bit0=0 ignored", 32'(irq), 1);
      wr_reg(2'd3, 16'h0001);
      chk(irq == 1'b0, "R6 irq cleared", 32'(irq), 0);

      // block mode, memory to device, four items; address write during run
      wr_reg(2'd1, 16'h2000);
      wr_reg(2'd2, 16'd4);
      wr_reg(2'd0, 16'h0005);
      push_items(16'h2000, 4, 1'b0);
      first_ack = -1;
      dev_req = 1'b1;
      do @(negedge clk); while (!bus_req);
      dev_req = 1'b0;
      wr_reg(2'd1, 16'h3000);   // R10 must be ignored
      while (!irq) @(negedge clk);
      chk(exp_q.size() == 0, "R8 whole count from one request", exp_q.size(), 0);
      chk(last_ack - first_ack == 3, "R8 items back to back",
          32'(last_ack - first_ack), 3);
      wr_reg(2'd3, 16'h0001);

      // demand mode, five items, pause after two; address continues (R4, R10)
      wr_reg(2'd2, 16'd5);
      wr_reg(2'd0, 16'h000B);
      push_items(16'h2004, 5, 1'b1);
      dev_req = 1'b1;
      k = 0;
      while (k < 2) begin
         @(negedge clk);
         if (dev_ack) k++;
      end
      dev_req = 1'b0;
      repeat (6) begin
         @(negedge clk);
         chk(!dev_ack, "R9 paused while request low", 32'(dev_ack), 0);
      end
      chk(!bus_req && !irq && exp_q.size() == 3, "R9 bus released at pause",
          32'({bus_req, irq}), 0);
      dev_req = 1'b1;
      while (!irq) @(negedge clk);
      dev_req = 1'b0;
      chk(exp_q.size() == 0, "R9 resumed to completion", exp_q.size(), 0);

      // R5 zero count: request with enable gives no bus request
      dev_req = 1'b1;
      repeat (5) @(negedge clk);
      chk(!bus_req && !dev_ack, "R5 no start with zero count",
          32'({bus_req, dev_ack}), 0);
      dev_req = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule